// File: doc/BRIEF.md
# Directory Writeback Completion Controller

This block sits on the directory side of a cache-coherence protocol and completes cache writebacks for a small table of tracked lines. A line is first put into a writeback-blocked state, and its current sharer set is loaded at that point. A writeback message then arrives. It carries the line data, a dirty flag, a size class, the sending node and a flag that says whether the line goes Exclusive or Owned. The controller checks the message and removes the sender from the sharer set. It parks the data in a per-line transaction buffer and issues a memory write request that carries the data. The line then stays busy in one of two wait states.

The directory copy of the data is written only when memory acknowledges. The data written is the data that comes back with the acknowledge. At that point the line settles in Owned or Exclusive, and the transaction buffer entry is released. A wakeup pulse names the line so that dependent requests can replay. The Exclusive path also pulses a probe-filter deallocate for the line.

A combinational lookup port serves line data. It reads the directory copy when that copy is valid, and the transaction buffer otherwise. A lookup in the middle of a writeback therefore returns the in-flight data. Any protocol violation sets a sticky error flag.

Top module: `wbdir_top`

## Requirements
- R1: After reset every line is in state Invalid (code 0). No line is busy, every pulse output is low and the error flag is low.
- R2: An asserted block request for a line that is not busy moves that line to WritebackBlocked (code 1) and loads its sharer set from the block sharer input.
- R3: A writeback to a WritebackBlocked line that is dirty and has size class 2 (writeback data) is accepted. The line moves to WaitOwned (code 2) when the exclusive flag is low, and to WaitExclusive (code 3) when it is high. The sender's bit is cleared from the line's sharer set, and the consume-writeback output pulses.
- R4: The memory write request (valid, line, data) appears in the cycle after the writeback is offered. It carries the writeback data and lasts one cycle.
- R5: A writeback that is not dirty, or whose size class is not 2, sets the error flag. It leaves the line state unchanged and issues no memory request.
- R6: States 1, 2 and 3 report the line busy. All other states report it not busy.
- R7: The directory copy changes only on the memory acknowledge, and it takes the data returned with the acknowledge. A later lookup returns that data.
- R8: An acknowledge to a WaitExclusive line moves it to Exclusive (code 5). In the next cycle it pulses probe-filter deallocate, wakeup and consume-acknowledge, each naming the line.
- R9: An acknowledge to a WaitOwned line moves it to Owned (code 4) and pulses wakeup and consume-acknowledge. It gives no probe-filter deallocate.
- R10: A lookup returns the directory copy if that copy is valid, or else the transaction buffer data with the from-buffer flag high. An asserted lookup that finds neither valid sets the error flag.
- R11: An acknowledge to a line in neither wait state, a writeback to a line that is not WritebackBlocked, or a block request to a busy line sets the error flag and leaves the line state unchanged.
- R12: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkValid | input | 1 | Block a line for writeback |
| blkLine | input | LINE_W | Line to block |
| blkSharers | input | NUM_NODES | Sharer set loaded on block |
| wbValid | input | 1 | Writeback message present |
| wbLine | input | LINE_W | Writeback line |
| wbData | input | DATA_W | Writeback data |
| wbDirty | input | 1 | Writeback marked dirty |
| wbSize | input | 2 | Size class, 2 = writeback data |
| wbExclusive | input | 1 | 1 = goes Exclusive, 0 = goes Owned |
| wbSender | input | NODE_W | Writing node |
| ackValid | input | 1 | Memory acknowledge present |
| ackLine | input | LINE_W | Acknowledged line |
| ackData | input | DATA_W | Data returned with acknowledge |
| lkValid | input | 1 | Lookup asserted |
| lkLine | input | LINE_W | Lookup line |
| lineStates | output | NUM_LINES*3 | State code per line, 3 bits each |
| busyVec | output | NUM_LINES | Busy bit per line |
| sharerVec | output | NUM_LINES*NUM_NODES | Sharer set per line |
| wbConsume | output | 1 | Writeback message consumed |
| memReqValid | output | 1 | Memory write request |
| memReqLine | output | LINE_W | Request line |
| memReqData | output | DATA_W | Request data |
| ackConsume | output | 1 | Acknowledge consumed |
| pfDealloc | output | 1 | Probe-filter deallocate pulse |
| pfLine | output | LINE_W | Line to deallocate |
| wakeValid | output | 1 | Wake dependents pulse |
| wakeLine | output | LINE_W | Line whose dependents wake |
| lkData | output | DATA_W | Lookup data |
| lkFromTbe | output | 1 | Lookup served from transaction buffer |
| errFlag | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with four lines, four nodes and 32-bit data. With four lines, a writeback on one line can overlap a block or an acknowledge on another line, and the Owned and Exclusive paths can both be in flight at once. With four nodes, sharer removal can be seen on sets that hold several members. Each error case runs from a fresh reset, so the sticky flag shows which stimulus raised it.

// File: rtl/wbdir_pkg.sv
package wbdir_pkg;
  typedef enum logic [2:0] {
    LS_INV    = 3'd0,
    LS_WBBLK  = 3'd1,
    LS_WAITO  = 3'd2,
    LS_WAITE  = 3'd3,
    LS_OWNED  = 3'd4,
    LS_EXCL   = 3'd5
  } lineState_t;

  localparam logic [1:0] SZ_WBDATA = 2'd2;

  typedef struct packed {
    logic blockGo;
    logic wbGo;
    logic wbExcl;
    logic ackGo;
    logic ackExcl;
  } strobe_t;
endpackage

// File: rtl/wbdir_ctrl.sv
module wbdir_ctrl
  import wbdir_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LINE_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   blkValid,
  input  logic [LINE_W-1:0]      blkLine,
  input  logic                   wbValid,
  input  logic [LINE_W-1:0]      wbLine,
  input  logic                   wbDirty,
  input  logic [1:0]             wbSize,
  input  logic                   wbExclusive,
  input  logic                   ackValid,
  input  logic [LINE_W-1:0]      ackLine,
  input  logic                   lkMiss,
  output strobe_t                strobe,
  output logic [NUM_LINES*3-1:0] lineStates,
  output logic [NUM_LINES-1:0]   busyVec,
  output logic                   errFlag
);
  lineState_t st [NUM_LINES];
  logic blkOk, wbOk, ackOk, errNow;

  function automatic logic isBusy(lineState_t s);
    return (s == LS_WBBLK) || (s == LS_WAITO) || (s == LS_WAITE);
  endfunction

  always_comb begin
    blkOk  = blkValid && !isBusy(st[blkLine]);
    wbOk   = wbValid && wbDirty && (wbSize == SZ_WBDATA) && (st[wbLine] == LS_WBBLK);
    ackOk  = ackValid && ((st[ackLine] == LS_WAITO) || (st[ackLine] == LS_WAITE));
    errNow = (blkValid && !blkOk) || (wbValid && !wbOk) || (ackValid && !ackOk) || lkMiss;
    strobe.blockGo = blkOk;
    strobe.wbGo    = wbOk;
    strobe.wbExcl  = wbExclusive;
    strobe.ackGo   = ackOk;
    strobe.ackExcl = (st[ackLine] == LS_WAITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) st[i] <= LS_INV;
      errFlag <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobe.blockGo && blkLine == LINE_W'(i))
          st[i] <= LS_WBBLK;
        else if (strobe.wbGo && wbLine == LINE_W'(i))
          st[i] <= strobe.wbExcl ? LS_WAITE : LS_WAITO;
        else if (strobe.ackGo && ackLine == LINE_W'(i))
          st[i] <= (st[i] == LS_WAITE) ? LS_EXCL : LS_OWNED;
      end
      if (errNow) errFlag <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
    assign lineStates[g*3 +: 3] = st[g];
    assign busyVec[g]           = isBusy(st[g]);
  end
endmodule

// File: rtl/wbdir_dp.sv
module wbdir_dp
  import wbdir_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_NODES = 4,
  parameter int DATA_W = 32,
  parameter int LINE_W = 2,
  parameter int NODE_W = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobe,
  input  logic [LINE_W-1:0]              blkLine,
  input  logic [NUM_NODES-1:0]           blkSharers,
  input  logic [LINE_W-1:0]              wbLine,
  input  logic [DATA_W-1:0]              wbData,
  input  logic [NODE_W-1:0]              wbSender,
  input  logic [LINE_W-1:0]              ackLine,
  input  logic [DATA_W-1:0]              ackData,
  input  logic                           lkValid,
  input  logic [LINE_W-1:0]              lkLine,
  output logic [NUM_LINES*NUM_NODES-1:0] sharerVec,
  output logic                           wbConsume,
  output logic                           memReqValid,
  output logic [LINE_W-1:0]              memReqLine,
  output logic [DATA_W-1:0]              memReqData,
  output logic                           ackConsume,
  output logic                           pfDealloc,
  output logic [LINE_W-1:0]              pfLine,
  output logic                           wakeValid,
  output logic [LINE_W-1:0]              wakeLine,
  output logic [DATA_W-1:0]              lkData,
  output logic                           lkFromTbe,
  output logic                           lkMiss
);
  logic [NUM_NODES-1:0] sharers [NUM_LINES];
  logic [DATA_W-1:0]    dirData [NUM_LINES];
  logic [DATA_W-1:0]    tbeData [NUM_LINES];
  logic [NUM_LINES-1:0] dirValid, tbeValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        sharers[i] <= '0;
        dirData[i] <= '0;
        tbeData[i] <= '0;
      end
      dirValid    <= '0;
      tbeValid    <= '0;
      wbConsume   <= 1'b0;
      memReqValid <= 1'b0;
      memReqLine  <= '0;
      memReqData  <= '0;
      ackConsume  <= 1'b0;
      pfDealloc   <= 1'b0;
      pfLine      <= '0;
      wakeValid   <= 1'b0;
      wakeLine    <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobe.blockGo && blkLine == LINE_W'(i))
          sharers[i] <= blkSharers;
        if (strobe.wbGo && wbLine == LINE_W'(i)) begin
          sharers[i]  <= sharers[i] & ~(NUM_NODES'(1) << wbSender);
          dirValid[i] <= 1'b0;
          tbeValid[i] <= 1'b1;
          tbeData[i]  <= wbData;
        end
        if (strobe.ackGo && ackLine == LINE_W'(i)) begin
          dirData[i]  <= ackData;
          dirValid[i] <= 1'b1;
          tbeValid[i] <= 1'b0;
        end
      end
      wbConsume   <= strobe.wbGo;
      memReqValid <= strobe.wbGo;
      if (strobe.wbGo) begin
        memReqLine <= wbLine;
        memReqData <= wbData;
      end
      ackConsume <= strobe.ackGo;
      wakeValid  <= strobe.ackGo;
      pfDealloc  <= strobe.ackGo && strobe.ackExcl;
      if (strobe.ackGo) begin
        wakeLine <= ackLine;
        pfLine   <= ackLine;
      end
    end
  end

  always_comb begin
    lkFromTbe = !dirValid[lkLine] && tbeValid[lkLine];
    if (dirValid[lkLine])      lkData = dirData[lkLine];
    else if (tbeValid[lkLine]) lkData = tbeData[lkLine];
    else                       lkData = '0;
    lkMiss = lkValid && !dirValid[lkLine] && !tbeValid[lkLine];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_shr
    assign sharerVec[g*NUM_NODES +: NUM_NODES] = sharers[g];
  end
endmodule

// File: rtl/wbdir_top.sv
module wbdir_top
  import wbdir_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_NODES = 4,
  parameter int DATA_W = 32,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           blkValid,
  input  logic [LINE_W-1:0]              blkLine,
  input  logic [NUM_NODES-1:0]           blkSharers,
  input  logic                           wbValid,
  input  logic [LINE_W-1:0]              wbLine,
  input  logic [DATA_W-1:0]              wbData,
  input  logic                           wbDirty,
  input  logic [1:0]                     wbSize,
  input  logic                           wbExclusive,
  input  logic [NODE_W-1:0]              wbSender,
  input  logic                           ackValid,
  input  logic [LINE_W-1:0]              ackLine,
  input  logic [DATA_W-1:0]              ackData,
  input  logic                           lkValid,
  input  logic [LINE_W-1:0]              lkLine,
  output logic [NUM_LINES*3-1:0]         lineStates,
  output logic [NUM_LINES-1:0]           busyVec,
  output logic [NUM_LINES*NUM_NODES-1:0] sharerVec,
  output logic                           wbConsume,
  output logic                           memReqValid,
  output logic [LINE_W-1:0]              memReqLine,
  output logic [DATA_W-1:0]              memReqData,
  output logic                           ackConsume,
  output logic                           pfDealloc,
  output logic [LINE_W-1:0]              pfLine,
  output logic                           wakeValid,
  output logic [LINE_W-1:0]              wakeLine,
  output logic [DATA_W-1:0]              lkData,
  output logic                           lkFromTbe,
  output logic                           errFlag
);
  strobe_t strobe;
  logic    lkMiss;

  wbdir_ctrl #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .blkValid(blkValid), .blkLine(blkLine),
    .wbValid(wbValid), .wbLine(wbLine), .wbDirty(wbDirty), .wbSize(wbSize),
    .wbExclusive(wbExclusive),
    .ackValid(ackValid), .ackLine(ackLine),
    .lkMiss(lkMiss),
    .strobe(strobe), .lineStates(lineStates), .busyVec(busyVec), .errFlag(errFlag)
  );

  wbdir_dp #(.NUM_LINES(NUM_LINES), .NUM_NODES(NUM_NODES), .DATA_W(DATA_W),
             .LINE_W(LINE_W), .NODE_W(NODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .blkLine(blkLine), .blkSharers(blkSharers),
    .wbLine(wbLine), .wbData(wbData), .wbSender(wbSender),
    .ackLine(ackLine), .ackData(ackData),
    .lkValid(lkValid), .lkLine(lkLine),
    .sharerVec(sharerVec), .wbConsume(wbConsume),
    .memReqValid(memReqValid), .memReqLine(memReqLine), .memReqData(memReqData),
    .ackConsume(ackConsume), .pfDealloc(pfDealloc), .pfLine(pfLine),
    .wakeValid(wakeValid), .wakeLine(wakeLine),
    .lkData(lkData), .lkFromTbe(lkFromTbe), .lkMiss(lkMiss)
  );
endmodule

// File: rtl/wbdir_checker.sv
module wbdir_checker #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_LINES*3-1:0] lineStates,
  input logic [NUM_LINES-1:0]   busyVec,
  input logic                   errFlag,
  input logic                   wbConsume,
  input logic                   memReqValid,
  input logic [LINE_W-1:0]      memReqLine,
  input logic                   ackConsume,
  input logic                   pfDealloc,
  input logic [LINE_W-1:0]      pfLine,
  input logic                   wakeValid,
  input logic [LINE_W-1:0]      wakeLine
);
  assert_req_follows_consume_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> wbConsume);

  assert_req_line_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busyVec[memReqLine]);

  assert_pf_with_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    pfDealloc |-> (wakeValid && ackConsume && wakeLine == pfLine));

  assert_pf_line_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    pfDealloc |-> (lineStates[pfLine*3 +: 3] == 3'd5));

  assert_wake_owned_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeValid && !pfDealloc) |-> (lineStates[wakeLine*3 +: 3] == 3'd4));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind wbdir_top wbdir_checker #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .lineStates(lineStates), .busyVec(busyVec),
  .errFlag(errFlag), .wbConsume(wbConsume), .memReqValid(memReqValid),
  .memReqLine(memReqLine), .ackConsume(ackConsume), .pfDealloc(pfDealloc),
  .pfLine(pfLine), .wakeValid(wakeValid), .wakeLine(wakeLine)
);

// File: tb/wbdir_top_bench.sv
module wbdir_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int NN = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkValid = 0; logic [1:0] blkLine = 0; logic [NN-1:0] blkSharers = 0;
  logic wbValid = 0; logic [1:0] wbLine = 0; logic [DW-1:0] wbData = 0;
  logic wbDirty = 0; logic [1:0] wbSize = 0; logic wbExclusive = 0; logic [1:0] wbSender = 0;
  logic ackValid = 0; logic [1:0] ackLine = 0; logic [DW-1:0] ackData = 0;
  logic lkValid = 0; logic [1:0] lkLine = 0;
  logic [NL*3-1:0] lineStates; logic [NL-1:0] busyVec; logic [NL*NN-1:0] sharerVec;
  logic wbConsume, memReqValid, ackConsume, pfDealloc, wakeValid, lkFromTbe, errFlag;
  logic [1:0] memReqLine, pfLine, wakeLine;
  logic [DW-1:0] memReqData, lkData;

  wbdir_top #(.NUM_LINES(NL), .NUM_NODES(NN), .DATA_W(DW)) u_wbdir_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  int mSt [NL]; int mSh [NL]; int mDirD [NL]; int mTbeD [NL];
  bit mDirV [NL]; bit mTbeV [NL];
  bit mErr, eWbC, eMemV, eAckC, ePf, eWake;
  int eMemL, eMemD, ePfL, eWakeL;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit mBusy(int s);
    return s == 1 || s == 2 || s == 3;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NL; i++) begin
      mSt[i] = 0; mSh[i] = 0; mDirD[i] = 0; mTbeD[i] = 0; mDirV[i] = 0; mTbeV[i] = 0;
    end
    mErr = 0; eWbC = 0; eMemV = 0; eAckC = 0; ePf = 0; eWake = 0;
    eMemL = 0; eMemD = 0; ePfL = 0; eWakeL = 0;
  endtask

  task automatic modelStep();
    bit bOk, wOk, aOk, miss;
    int oldAck;
    bOk = blkValid && !mBusy(mSt[blkLine]);
    wOk = wbValid && wbDirty && wbSize == 2 && mSt[wbLine] == 1;
    aOk = ackValid && (mSt[ackLine] == 2 || mSt[ackLine] == 3);
    miss = lkValid && !mDirV[lkLine] && !mTbeV[lkLine];
    oldAck = mSt[ackLine];
    if ((blkValid && !bOk) || (wbValid && !wOk) || (ackValid && !aOk) || miss) mErr = 1;
    eWbC = wOk; eMemV = wOk;
    if (wOk) begin eMemL = wbLine; eMemD = wbData; end
    eAckC = aOk; eWake = aOk; ePf = aOk && oldAck == 3;
    if (aOk) begin ePfL = ackLine; eWakeL = ackLine; end
    if (bOk) begin mSt[blkLine] = 1; mSh[blkLine] = blkSharers; end
    if (wOk) begin
      mSt[wbLine] = wbExclusive ? 3 : 2;
      mSh[wbLine] = mSh[wbLine] & ~(1 << wbSender);
      mDirV[wbLine] = 0; mTbeV[wbLine] = 1; mTbeD[wbLine] = wbData;
    end
    if (aOk) begin
      mSt[ackLine] = (oldAck == 3) ? 5 : 4;
      mDirD[ackLine] = ackData; mDirV[ackLine] = 1; mTbeV[ackLine] = 0;
    end
  endtask

  task automatic compareAll();
    logic [NL*3-1:0] expSt; logic [NL-1:0] expBusy; logic [NL*NN-1:0] expSh;
    int expLk; bit expTbe;
    for (int i = 0; i < NL; i++) begin
      expSt[i*3 +: 3] = mSt[i][2:0];
      expBusy[i] = mBusy(mSt[i]);
      expSh[i*NN +: NN] = mSh[i][NN-1:0];
    end
    expTbe = !mDirV[lkLine] && mTbeV[lkLine];
    expLk = mDirV[lkLine] ? mDirD[lkLine] : (mTbeV[lkLine] ? mTbeD[lkLine] : 0);
    check(lineStates == expSt, "R3 states", lineStates, expSt);
    check(busyVec == expBusy, "R6 busy", busyVec, expBusy);
    check(sharerVec == expSh, "R2 sharers", sharerVec, expSh);
    check(wbConsume == eWbC && memReqValid == eMemV, "R4 req valid", memReqValid, eMemV);
    if (eMemV) check(memReqLine == eMemL[1:0] && memReqData == eMemD[DW-1:0],
                     "R4 req data", memReqData, eMemD);
    check(pfDealloc == ePf, "R8 pfDealloc", pfDealloc, ePf);
    if (ePf) check(pfLine == ePfL[1:0], "R8 pfLine", pfLine, ePfL);
    check(wakeValid == eWake && ackConsume == eAckC, "R9 wake", wakeValid, eWake);
    if (eWake) check(wakeLine == eWakeL[1:0], "R9 wakeLine", wakeLine, eWakeL);
    check(errFlag == mErr, "R12 err", errFlag, mErr);
    check(lkData == expLk[DW-1:0] && lkFromTbe == expTbe, "R10 lookup", lkData, expLk);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    blkValid = 0; wbValid = 0; ackValid = 0; lkValid = 0;
  endtask

  task automatic doReset();
    blkValid = 0; wbValid = 0; ackValid = 0; lkValid = 0;
    rstN = 0;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    compareAll();
  endtask

  task automatic putWb(int line, int data, bit dirty, int size, bit excl, int sender);
    wbValid = 1; wbLine = 2'(line); wbData = DW'(data); wbDirty = dirty;
    wbSize = 2'(size); wbExclusive = excl; wbSender = 2'(sender);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    check(lineStates == '0 && busyVec == '0 && errFlag == 0 && !memReqValid && !pfDealloc && !wakeValid,
          "R1 reset", lineStates, 0);
    lkValid = 1; lkLine = 3; tick();
    check(errFlag == 1, "R10 miss error", errFlag, 1);
    tick(); tick();
    check(errFlag == 1, "R12 sticky", errFlag, 1);

    doReset();
    blkValid = 1; blkLine = 0; blkSharers = 4'b0111; tick();
    check(lineStates[2:0] == 1 && busyVec[0], "R2 blocked", lineStates[2:0], 1);
    putWb(0, 32'hA5A5_0001, 1, 2, 0, 1);
    blkValid = 1; blkLine = 1; blkSharers = 4'b1001;
    tick();
    check(lineStates[2:0] == 2 && sharerVec[3:0] == 4'b0101, "R3 wait owned", sharerVec[3:0], 4'b0101);
    check(memReqValid && memReqData == 32'hA5A5_0001 && memReqLine == 0, "R4 request", memReqData, 32'hA5A5_0001);
    lkLine = 0; #1;
    check(lkData == 32'hA5A5_0001 && lkFromTbe, "R10 from buffer", lkData, 32'hA5A5_0001);
    check(busyVec[0] == 1, "R6 busy wait", busyVec[0], 1);
    putWb(1, 32'h0000_1111, 1, 2, 1, 3);
    ackValid = 1; ackLine = 0; ackData = 32'hB0B0_0002;
    tick();
    check(lineStates[2:0] == 4 && wakeValid && !pfDealloc, "R9 owned", lineStates[2:0], 4);
    lkLine = 0; #1;
    check(lkData == 32'hB0B0_0002 && !lkFromTbe, "R7 committed ack data", lkData, 32'hB0B0_0002);
    check(lineStates[5:3] == 3 && sharerVec[7:4] == 4'b0001, "R3 wait exclusive", lineStates[5:3], 3);
    ackValid = 1; ackLine = 1; ackData = 32'hC3C3_0003;
    tick();
    check(lineStates[5:3] == 5 && pfDealloc && pfLine == 1, "R8 exclusive", lineStates[5:3], 5);
    lkLine = 1; #1;
    check(lkData == 32'hC3C3_0003, "R7 exclusive data", lkData, 32'hC3C3_0003);
    check(errFlag == 0, "R11 clean run", errFlag, 0);
    tick();

    doReset();
    blkValid = 1; blkLine = 2; blkSharers = 4'b0011; tick();
    putWb(2, 32'h1234, 0, 2, 0, 0); tick();
    check(errFlag && lineStates[8:6] == 1 && !memReqValid, "R5 not dirty", lineStates[8:6], 1);
    doReset();
    blkValid = 1; blkLine = 2; blkSharers = 4'b0011; tick();
    putWb(2, 32'h1234, 1, 1, 0, 0); tick();
    check(errFlag && lineStates[8:6] == 1 && !memReqValid, "R5 bad size", lineStates[8:6], 1);

    doReset();
    ackValid = 1; ackLine = 3; ackData = 32'h55; tick();
    check(errFlag && lineStates[11:9] == 0 && !wakeValid, "R11 stray ack", lineStates[11:9], 0);
    doReset();
    putWb(3, 32'h77, 1, 2, 0, 0); tick();
    check(errFlag && lineStates[11:9] == 0, "R11 wb not blocked", lineStates[11:9], 0);
    doReset();
    blkValid = 1; blkLine = 0; blkSharers = 4'b0001; tick();
    blkValid = 1; blkLine = 0; blkSharers = 4'b1111; tick();
    check(errFlag && sharerVec[3:0] == 4'b0001, "R11 block busy", sharerVec[3:0], 4'b0001);
    tick(); tick();
    check(errFlag, "R12 sticky later", errFlag, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule